// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Frame Receiver

This block takes a single asynchronous serial line and turns its 10-bit frames into bytes. Each frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit. A companion baud generator supplies a one-cycle enable, `tick_16x`, that pulses sixteen times per bit period. The receiver runs every decision at that rate. The line passes through a synchronizer first. Reception begins at a detected high-to-low transition. At that transition the per-bit phase counter restarts, so that bit boundaries line up with the incoming waveform. Each bit is the majority of three samples taken around the middle of the bit.

A falsely triggered start is abandoned. Frame completion is tracked by a nine-bit shift register preloaded with all ones: the frame ends when the start bit reaches the leftmost stage. After one last shift the frame is committed, but only if the previous byte has been acknowledged and the address-filter rule allows it. On commit the block updates the data byte and the stop-bit copy, and raises a ready flag. That flag stays set until the consumer pulses a clear.

Top module: `uart_mvote_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rx_ready`, `rx_data` and `rx_stop` become 0.
- R2: A frame of one low start bit, 8 data bits least significant first and one stop bit, each lasting 16 `tick_16x` pulses, delivers the data byte on `rx_data` (bit i = i-th data bit received) with `rx_ready` set.
- R3: Each bit is the majority of the line values at phase counts 7, 8 and 9 of its bit period (phase 0 = the tick that detected the falling edge). A single inverted sample does not change the bit, and an inversion covering all three samples does.
- R4: If the voted start bit is 1, the attempt is dropped with no output change, and the next falling edge starts a new frame.
- R5: With `rx_ready` low and `mp_filter` low, a finished frame commits whatever its stop bit, and `rx_stop` takes the received stop value.
- R6: With `mp_filter` high, a frame whose stop bit is 0 is discarded: `rx_ready`, `rx_data` and `rx_stop` are unchanged.
- R7: A frame that finishes while `rx_ready` is still high is discarded, leaving `rx_data` and `rx_stop` unchanged.
- R8: `rx_ready` stays high until `ready_clr` is sampled high, which clears it on the next edge. A commit in the same cycle takes priority, but only when `rx_ready` was low.
- R9: High-to-low transitions of the line inside a frame do not restart reception.
- R10: After a commit or a discard, the receiver accepts the next frame without any other action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_16x | input | 1 | One-cycle enable, 16 per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| mp_filter | input | 1 | When high, frames with a 0 stop bit are not committed |
| ready_clr | input | 1 | Clears `rx_ready` |
| rx_data | output | 8 | Last committed data byte |
| rx_stop | output | 1 | Stop bit of the last committed frame |
| rx_ready | output | 1 | Frame-ready flag |

## Verification
The embedded assertions watch the ready flag on every cycle. They check that it holds until cleared and drops after a clear. They check that the data byte moves only when the flag rises, that a commit never ignores the address-filter rule, and that a rejected start returns the receiver to idle. The mapping of the serial waveform to byte values can only be shown by the bench's scenarios. The same holds for the majority behaviour under injected glitches, for discards caused by an unacknowledged byte, and for recovery after a false start. The bench sweeps all 256 byte values and then runs each gating case.

// File: rtl/uart_mvote_pkg.sv
// Shared types for the majority-vote frame receiver.
package uart_mvote_pkg;
    // Receive control states: waiting for an edge, judging start, collecting bits
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
// Synchronizes the asynchronous serial line and reports a high-to-low
// transition seen between two consecutive sample ticks.
// Assumes: tick is a one-cycle enable; the line idles high.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    // Metastability chain, reset to the idle level
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_in};
    end

    assign line_s = chain[STAGES-1];

    // Line value at the previous sample tick
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_q <= 1'b1;
        else if (tick) prev_q <= line_s;
    end

    assign fall = tick && prev_q && !line_s;
endmodule

// File: rtl/rx_bit_voter.sv
// Phase counter over one bit period plus a three-sample majority voter.
// The counter restarts on 'restart' (phase 0) and advances on each tick
// while 'active'. A bit is decided at the third sample point.
// Assumes: OVERSAMPLE >= 4 so the three sample points fit in the period.
module rx_bit_voter #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic active,
    input  logic line_s,
    output logic bit_valid,
    output logic bit_val
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int MID   = OVERSAMPLE / 2;
    localparam logic [CNT_W-1:0] PH_A    = CNT_W'(MID - 1);
    localparam logic [CNT_W-1:0] PH_B    = CNT_W'(MID);
    localparam logic [CNT_W-1:0] PH_C    = CNT_W'(MID + 1);
    localparam logic [CNT_W-1:0] PH_LAST = CNT_W'(OVERSAMPLE - 1);

    logic [CNT_W-1:0] phase_q;
    logic             samp_a_q;
    logic             samp_b_q;

    // Phase within the bit period, realigned on every detected start edge
    always_ff @(posedge clk) begin
        if (!rst_n)                phase_q <= '0;
        else if (restart)          phase_q <= '0;
        else if (tick && active)   phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end

    // Capture the first two of the three votes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_a_q <= 1'b1;
            samp_b_q <= 1'b1;
        end else if (tick && active) begin
            if (phase_q == PH_A) samp_a_q <= line_s;
            if (phase_q == PH_B) samp_b_q <= line_s;
        end
    end

    assign bit_valid = tick && active && !restart && (phase_q == PH_C);
    assign bit_val   = (samp_a_q & samp_b_q) | (samp_a_q & line_s) | (samp_b_q & line_s);
endmodule

// File: rtl/rx_frame_ctl.sv
// Frame control: start-bit qualification, the all-ones preloaded shift
// register that marks end of frame, and the gated commit to the outputs.
// Assumes: bit_valid pulses once per bit period while busy.
module rx_frame_ctl
    import uart_mvote_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              bit_valid,
    input  logic              bit_val,
    input  logic              mp_filter,
    input  logic              ready_clr,
    output logic              frame_start,
    output logic              busy,
    output logic [DATA_W-1:0] data_o,
    output logic              stop_o,
    output logic              ready_o
);
    localparam int SR_W = DATA_W + 1;

    rx_state_e         state_q;
    logic [SR_W-1:0]   shreg_q;
    logic [SR_W-1:0]   last_word;
    logic [DATA_W-1:0] last_data;
    logic              last_bit;
    logic              commit_ok;

    assign frame_start = (state_q == RX_IDLE) && fall;
    assign busy        = (state_q != RX_IDLE);
    assign last_bit    = (state_q == RX_BITS) && bit_valid && !shreg_q[SR_W-1];
    assign last_word   = {shreg_q[SR_W-2:0], bit_val};
    assign commit_ok   = last_bit && !ready_o && (!mp_filter || bit_val);

    // Oldest data bit sits highest in the word: reverse into byte order
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign last_data[i] = last_word[SR_W-1-i];
    end

    // Sequencing: idle, start judgement, bit collection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            case (state_q)
                RX_IDLE:  if (fall) state_q <= RX_START;
                RX_START: if (bit_valid) state_q <= bit_val ? RX_IDLE : RX_BITS;
                RX_BITS:  if (last_bit) state_q <= RX_IDLE;
                default:  state_q <= RX_IDLE;
            endcase
        end
    end

    // Shift register: preloaded with ones, bits enter at the right
    always_ff @(posedge clk) begin
        if (!rst_n)                                 shreg_q <= '1;
        else if (frame_start)                       shreg_q <= '1;
        else if (busy && bit_valid && !last_bit)    shreg_q <= {shreg_q[SR_W-2:0], bit_val};
    end

    // Output registers, written only by a successful commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            stop_o <= 1'b0;
        end else if (commit_ok) begin
            data_o <= last_data;
            stop_o <= bit_val;
        end
    end

    // Ready flag: set by commit, cleared by the consumer
    always_ff @(posedge clk) begin
        if (!rst_n)         ready_o <= 1'b0;
        else if (commit_ok) ready_o <= 1'b1;
        else if (ready_clr) ready_o <= 1'b0;
    end

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !ready_clr) |=> ready_o);
    // R8
    ready_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && ready_clr) |=> !ready_o);
    // R7
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(ready_o) |-> ($stable(data_o) && $stable(stop_o)));
    // R6
    filter_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (stop_o || !$past(mp_filter)));
    // R4
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START && bit_valid && bit_val) |=> (state_q == RX_IDLE));
endmodule

// File: rtl/uart_mvote_rx.sv
// Top of the majority-vote frame receiver: synchronizer and edge detector,
// bit-phase voter, and frame control.
// Assumes: tick_16x pulses OVERSAMPLE times per bit period.
module uart_mvote_rx #(
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16x,
    input  logic              rx_line,
    input  logic              mp_filter,
    input  logic              ready_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_stop,
    output logic              rx_ready
);
    logic line_s;
    logic fall;
    logic frame_start;
    logic busy;
    logic bit_valid;
    logic bit_val;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_16x),
        .line_in (rx_line),
        .line_s  (line_s),
        .fall    (fall)
    );

    rx_bit_voter #(.OVERSAMPLE(OVERSAMPLE)) u_voter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_16x),
        .restart   (frame_start),
        .active    (busy),
        .line_s    (line_s),
        .bit_valid (bit_valid),
        .bit_val   (bit_val)
    );

    rx_frame_ctl #(.DATA_W(DATA_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall        (fall),
        .bit_valid   (bit_valid),
        .bit_val     (bit_val),
        .mp_filter   (mp_filter),
        .ready_clr   (ready_clr),
        .frame_start (frame_start),
        .busy        (busy),
        .data_o      (rx_data),
        .stop_o      (rx_stop),
        .ready_o     (rx_ready)
    );
endmodule

// File: tb/tb_uart_mvote_rx.sv
module tb_uart_mvote_rx;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;
    localparam int BIT_TICKS  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16x = 1'b0;
    logic       rx_line = 1'b1;
    logic       mp_filter = 1'b0;
    logic       ready_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_stop;
    logic       rx_ready;
    int         tdiv = 0;
    int         checks = 0;
    int         fails = 0;

    uart_mvote_rx dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_16x  (tick_16x),
        .rx_line   (rx_line),
        .mp_filter (mp_filter),
        .ready_clr (ready_clr),
        .rx_data   (rx_data),
        .rx_stop   (rx_stop),
        .rx_ready  (rx_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Oversample enable, changed away from the active edge
    always @(negedge clk) begin
        tdiv     = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick_16x = (tdiv == 0);
    end

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick_16x) @(posedge clk);
        end
        @(negedge clk);
    endtask

    // One bit period, optionally inverted for glen ticks from offset gstart
    task automatic drive_bit(input logic v, input bit glitch, input int gstart, input int glen);
        rx_line = v;
        if (glitch) begin
            wait_ticks(gstart);
            rx_line = ~v;
            wait_ticks(glen);
            rx_line = v;
            wait_ticks(BIT_TICKS - gstart - glen);
        end else begin
            wait_ticks(BIT_TICKS);
        end
    endtask

    // gbit: -1 none, 0..9 one bit index (0 = start), 10 = every bit
    task automatic send_frame(input logic [7:0] b, input logic stop, input int gbit,
                              input int gstart, input int glen);
        drive_bit(1'b0, (gbit == 0 || gbit == 10), gstart, glen);
        for (int i = 0; i < 8; i++)
            drive_bit(b[i], (gbit == i + 1 || gbit == 10), gstart, glen);
        drive_bit(stop, (gbit == 9 || gbit == 10), gstart, glen);
        rx_line = 1'b1;
        wait_ticks(4);
    endtask

    task automatic clear_ready();
        ready_clr = 1'b1;
        @(negedge clk);
        ready_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_out(input string req, input logic [7:0] ed, input logic es, input logic er);
        checks++;
        if (rx_data !== ed || rx_stop !== es || rx_ready !== er) begin
            fails++;
            $display("FAIL %s: actual data=%02h stop=%0b ready=%0b expected data=%02h stop=%0b ready=%0b",
                     req, rx_data, rx_stop, rx_ready, ed, es, er);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL R2: watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check_out("R1", 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_ticks(20);
        check_out("R1", 8'h00, 1'b0, 1'b0);

        // R2 / R9: every byte value, internal falling edges included
        for (int v = 0; v < 256; v++) begin
            send_frame(8'(v), 1'b1, -1, 0, 0);
            check_out("R2", 8'(v), 1'b1, 1'b1);
            clear_ready();
        end

        // R8: flag persists without a clear, then drops on clear
        send_frame(8'h96, 1'b1, -1, 0, 0);
        wait_ticks(60);
        check_out("R8", 8'h96, 1'b1, 1'b1);
        clear_ready();
        check_out("R8", 8'h96, 1'b1, 1'b0);

        // R5: stop bit 0 committed when the filter is off
        send_frame(8'h3C, 1'b0, -1, 0, 0);
        check_out("R5", 8'h3C, 1'b0, 1'b1);
        clear_ready();

        // R6: filter on, stop bit 0 discarded
        mp_filter = 1'b1;
        send_frame(8'h81, 1'b0, -1, 0, 0);
        check_out("R6", 8'h3C, 1'b0, 1'b0);
        // R10: next frame accepted after the discard
        send_frame(8'h81, 1'b1, -1, 0, 0);
        check_out("R10", 8'h81, 1'b1, 1'b1);
        clear_ready();
        mp_filter = 1'b0;

        // R7: unacknowledged byte blocks the following frame
        send_frame(8'h11, 1'b1, -1, 0, 0);
        send_frame(8'h22, 1'b0, -1, 0, 0);
        check_out("R7", 8'h11, 1'b1, 1'b1);
        clear_ready();
        send_frame(8'h44, 1'b1, -1, 0, 0);
        check_out("R10", 8'h44, 1'b1, 1'b1);
        clear_ready();

        // R4: short low pulse judged as a false start
        rx_line = 1'b0;
        wait_ticks(4);
        rx_line = 1'b1;
        wait_ticks(30);
        check_out("R4", 8'h44, 1'b1, 1'b0);
        send_frame(8'h5A, 1'b1, -1, 0, 0);
        check_out("R4", 8'h5A, 1'b1, 1'b1);
        clear_ready();

        // R3: one inverted sample per bit is outvoted
        send_frame(8'hA5, 1'b1, 10, 8, 1);
        check_out("R3", 8'hA5, 1'b1, 1'b1);
        clear_ready();
        // R3: inversion across all three samples of data bit 0 flips it
        send_frame(8'hA5, 1'b1, 1, 7, 3);
        check_out("R3", 8'hA4, 1'b1, 1'b1);
        clear_ready();
        // R3: same on data bit 7
        send_frame(8'h0F, 1'b1, 8, 7, 3);
        check_out("R3", 8'h8F, 1'b1, 1'b1);
        clear_ready();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule